// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits in an always-on power domain between a vector of shared peripheral interrupt lines and a downstream interrupt controller. Every line passes through to the controller on every cycle. Two lines are external active-low system pins, and the block inverts them so that the controller always sees active-high inputs. Software cannot mask the pass-through path.

Each CPU has its own bank of 32-bit enable registers. When an enabled line is active, the block raises that CPU's wakeup request, which lets the core leave a low-power state. A mode register sets how the requests combine. In independent mode each core has its own wakeup output. In shared mode any request wakes every core, because the cores enter and leave the off state together.

Top module: `wkg_wakeup_gen`

## Requirements
- R1: The enable register for CPU c and index k is at byte address c*0x400 + 4*k, for k below NUM_BANKS (default 5, giving 160 lines). Line n maps to register index n>>5, bit n mod 32. A write followed by a read of the same address returns the written value.
- R2: After reset, every enable register and the mode register read zero, and wake_out and irq_fwd are low.
- R3: irq_fwd[n] equals irq_in[n] one clock later, whatever the enable registers hold, for every line except lines 7 and 119.
- R4: Lines 7 and 119 are active-low. irq_fwd carries the inverse of irq_in for these lines one clock later, and a low level counts as active for wakeup.
- R5: When mode bit 5 is 1 (independent mode), wake_out[c] is, one clock after the inputs, the OR over all lines of (line active AND CPU c's enable bit).
- R6: When mode bit 5 is 0 (shared mode, the reset value), every bit of wake_out is, one clock after the inputs, the OR of all CPUs' requests as defined in R5.
- R7: The mode register is at byte address NUM_CPUS*0x400 (0x800 by default), and only its bit 5 is stored; its other bits read zero. Any other address, and any address with bits [1:0] nonzero, reads zero, and writes to it change no state.
- R8: Writing 0xFFFFFFFF to an enable register enables all 32 of its lines. Writing 0 masks all 32.
- R9: bus_rdata carries the read value one clock after a cycle with bus_rd high, and is zero after a cycle with bus_rd low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_BANKS*32 | Incoming interrupt lines |
| irq_fwd | output | NUM_BANKS*32 | Registered lines to the downstream controller |
| wake_out | output | NUM_CPUS | Registered per-CPU wakeup requests |

## Verification
The hardest situation to reach is a change of mode or enables in the same cycle that a line goes active. The outputs then have to follow the settings held before that edge, not the new write.

The random phase combines writes to the mode and enable registers with sparse interrupt patterns, so these collisions occur often. Those patterns sometimes pull the active-low pins low. Directed cases cover the cases the random phase reaches less often: the inverted pins, all-ones and all-zero writes, and writes to unaligned or unmapped addresses.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
  localparam int WORD_W   = 32;
  localparam int MODE_BIT = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_ENABLE,
    TGT_MODE
  } tgt_e;
endpackage

// File: rtl/wkg_addr_decode.sv
module wkg_addr_decode
  import wkg_pkg::*;
#(
  parameter int NUM_CPUS    = 2,
  parameter int NUM_BANKS   = 5,
  parameter int ADDR_W      = 12,
  parameter int STRIDE_BITS = 10,
  parameter int CPU_W       = 1,
  parameter int IDX_W       = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [CPU_W-1:0]  cpu_sel,
  output logic [IDX_W-1:0]  word_idx
);
  localparam int CF_W = ADDR_W - STRIDE_BITS;
  localparam int WF_W = STRIDE_BITS - 2;
  localparam logic [CF_W-1:0] CPU_LIMIT  = CF_W'(NUM_CPUS);
  localparam logic [WF_W-1:0] WORD_LIMIT = WF_W'(NUM_BANKS);

  logic [CF_W-1:0] cpu_field;
  logic [WF_W-1:0] word_field;
  logic            aligned;

  assign cpu_field  = addr[ADDR_W-1:STRIDE_BITS];
  assign word_field = addr[STRIDE_BITS-1:2];
  assign aligned    = (addr[1:0] == 2'b00);
  assign cpu_sel    = cpu_field[CPU_W-1:0];
  assign word_idx   = word_field[IDX_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (aligned) begin
      if (cpu_field < CPU_LIMIT && word_field < WORD_LIMIT)
        tgt = TGT_ENABLE;
      else if (cpu_field == CPU_LIMIT && word_field == '0)
        tgt = TGT_MODE;
    end
  end
endmodule

// File: rtl/wkg_polarity.sv
module wkg_polarity #(
  parameter int NUM_LINES  = 160,
  parameter int INV_LINE_A = 7,
  parameter int INV_LINE_B = 119
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_norm,
  output logic [NUM_LINES-1:0] irq_fwd
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == INV_LINE_A || i == INV_LINE_B) begin : g_inv
      assign irq_norm[i] = ~irq_in[i];
    end else begin : g_pass
      assign irq_norm[i] = irq_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_fwd <= '0;
    else     irq_fwd <= irq_norm;
  end
endmodule

// File: rtl/wkg_enable_bank.sv
module wkg_enable_bank
  import wkg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int IDX_W     = 3,
  parameter int NUM_LINES = NUM_BANKS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  word_t                wr_data,
  output word_t                rd_data,
  input  logic [NUM_LINES-1:0] irq_norm,
  output logic                 wake_req
);
  localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_BANKS);

  word_t                en_q [NUM_BANKS];
  logic [NUM_LINES-1:0] en_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) en_q[b] <= '0;
    end else if (wr_en && idx < IDX_LIMIT) begin
      en_q[idx] <= wr_data;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
    assign en_flat[b*WORD_W +: WORD_W] = en_q[b];
  end

  assign rd_data  = (idx < IDX_LIMIT) ? en_q[idx] : '0;
  assign wake_req = |(en_flat & irq_norm);
endmodule

// File: rtl/wkg_wake_combine.sv
module wkg_wake_combine #(
  parameter int NUM_CPUS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CPUS-1:0] req,
  input  logic                indep,
  output logic [NUM_CPUS-1:0] wake_out
);
  logic any_req;
  assign any_req = |req;

  always_ff @(posedge clk) begin
    if (rst)        wake_out <= '0;
    else if (indep) wake_out <= req;
    else            wake_out <= {NUM_CPUS{any_req}};
  end
endmodule

// File: rtl/wkg_wakeup_gen.sv
module wkg_wakeup_gen
  import wkg_pkg::*;
#(
  parameter int NUM_CPUS   = 2,
  parameter int NUM_BANKS  = 5,
  parameter int ADDR_W     = 12,
  parameter int CPU_STRIDE = 1024,
  parameter int INV_LINE_A = 7,
  parameter int INV_LINE_B = 119
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0] irq_in,
  output logic [NUM_BANKS*WORD_W-1:0] irq_fwd,
  output logic [NUM_CPUS-1:0]         wake_out
);
  localparam int NUM_LINES   = NUM_BANKS * WORD_W;
  localparam int STRIDE_BITS = $clog2(CPU_STRIDE);
  localparam int CPU_W       = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int IDX_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  tgt_e                 tgt;
  logic [CPU_W-1:0]     cpu_sel;
  logic [IDX_W-1:0]     word_idx;
  logic [NUM_LINES-1:0] irq_norm;
  logic [NUM_CPUS-1:0]  req;
  word_t                bank_rd [NUM_CPUS];
  word_t                rd_mux;
  logic                 mode_q;

  wkg_addr_decode #(
    .NUM_CPUS(NUM_CPUS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
    .STRIDE_BITS(STRIDE_BITS), .CPU_W(CPU_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .tgt(tgt), .cpu_sel(cpu_sel), .word_idx(word_idx)
  );

  wkg_polarity #(
    .NUM_LINES(NUM_LINES), .INV_LINE_A(INV_LINE_A), .INV_LINE_B(INV_LINE_B)
  ) u_pol (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_norm(irq_norm), .irq_fwd(irq_fwd)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic bank_wr;
    assign bank_wr = bus_wr && (tgt == TGT_ENABLE) && (cpu_sel == CPU_W'(c));

    wkg_enable_bank #(
      .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .NUM_LINES(NUM_LINES)
    ) u_bank (
      .clk(clk), .rst(rst), .wr_en(bank_wr), .idx(word_idx),
      .wr_data(bus_wdata), .rd_data(bank_rd[c]),
      .irq_norm(irq_norm), .wake_req(req[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                              mode_q <= 1'b0;
    else if (bus_wr && tgt == TGT_MODE)   mode_q <= bus_wdata[MODE_BIT];
  end

  always_comb begin
    rd_mux = '0;
    case (tgt)
      TGT_ENABLE: rd_mux = bank_rd[cpu_sel];
      TGT_MODE:   rd_mux[MODE_BIT] = mode_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  wkg_wake_combine #(.NUM_CPUS(NUM_CPUS)) u_comb (
    .clk(clk), .rst(rst), .req(req), .indep(mode_q), .wake_out(wake_out)
  );
endmodule

// File: rtl/wkg_wakeup_gen_chk.sv
module wkg_wakeup_gen_chk #(
  parameter int NUM_CPUS   = 2,
  parameter int NUM_LINES  = 160,
  parameter int ADDR_W     = 12,
  parameter int CPU_STRIDE = 1024,
  parameter int INV_LINE_A = 7,
  parameter int PLAIN_LINE = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_in,
  input logic [NUM_LINES-1:0] irq_fwd,
  input logic [NUM_LINES-1:0] irq_norm,
  input logic [NUM_CPUS-1:0]  wake_out,
  input logic                 mode_q
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_CPUS * CPU_STRIDE);

  p_fwd_plain_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_fwd[PLAIN_LINE] == $past(irq_in[PLAIN_LINE]));

  p_fwd_inv_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_fwd[INV_LINE_A] == !$past(irq_in[INV_LINE_A]));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irq_norm) == '0) |-> wake_out == '0);

  p_shared_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_q)) |-> (wake_out == '0 || wake_out == '1));

  p_mode_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && $past(bus_addr) == MODE_ADDR)
      |-> (bus_rdata & ~32'h0000_0020) == '0);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> bus_rdata == '0);
endmodule

bind wkg_wakeup_gen wkg_wakeup_gen_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_BANKS*32), .ADDR_W(ADDR_W),
  .CPU_STRIDE(CPU_STRIDE), .INV_LINE_A(INV_LINE_A), .PLAIN_LINE(0)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_fwd(irq_fwd),
  .irq_norm(irq_norm), .wake_out(wake_out), .mode_q(mode_q)
);

// File: tb/test_wkg_wakeup_gen.sv
`timescale 1ns/1ps
module test_wkg_wakeup_gen;
  localparam int NC = 2;
  localparam int NB = 5;
  localparam int NL = NB * 32;
  localparam int AW = 12;
  localparam logic [NL-1:0] INV_MASK = (NL'(1) << 7) | (NL'(1) << 119);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in = INV_MASK;
  logic [NL-1:0] irq_fwd;
  logic [NC-1:0] wake_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] en_m [NC][NB];
  bit          mode_m;

  always #2.5 clk = ~clk;

  wkg_wakeup_gen i_wkg_wakeup_gen (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_fwd(irq_fwd), .wake_out(wake_out)
  );

  function automatic int addr_kind(input logic [AW-1:0] a, output int c, output int w);
    c = int'(a) >> 10;
    w = (int'(a) >> 2) & 8'hFF;
    if (a[1:0] != 2'b00) return 0;
    if (c < NC && w < NB) return 1;
    if (c == NC && w == 0) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int c, w, k;
    k = addr_kind(a, c, w);
    if (k == 1) return en_m[c][w];
    if (k == 2) return {26'b0, mode_m, 5'b0};
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int c, w, k;
    k = addr_kind(a, c, w);
    if (k == 1) en_m[c][w] = d;
    else if (k == 2) mode_m = d[5];
  endfunction

  function automatic logic [NC-1:0] exp_wake(input logic [NL-1:0] irq);
    logic [NL-1:0] norm;
    logic [NL-1:0] flat;
    logic [NC-1:0] req;
    norm = irq ^ INV_MASK;
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < NB; b++) flat[b*32 +: 32] = en_m[c][b];
      req[c] = |(norm & flat);
    end
    return mode_m ? req : {NC{|req}};
  endfunction

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [NL-1:0] irq, input string tag);
    logic [31:0]   er;
    logic [NL-1:0] ef;
    logic [NC-1:0] ew;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; irq_in = irq;
    er = rd ? model_read(a) : 32'h0;
    ef = irq ^ INV_MASK;
    ew = exp_wake(irq);
    @(posedge clk);
    #1;
    check("R3/R4 forward", NL'(irq_fwd), ef);
    check(mode_m ? "R5 wake indep" : "R6 wake shared", NL'(wake_out), NL'(ew));
    if (rd) check(tag, NL'(bus_rdata), NL'(er));
    else    check("R9 idle rdata", NL'(bus_rdata), '0);
    if (wr) model_write(a, d);
  endtask

  function automatic logic [NL-1:0] act_line(input logic [NL-1:0] base, input int n);
    return base ^ (NL'(1) << n);
  endfunction

  function automatic logic [NL-1:0] rand_irq();
    logic [NL-1:0] v;
    v = INV_MASK;
    for (int i = 0; i < int'($urandom % 4); i++) v = act_line(v, int'($urandom % NL));
    if ($urandom % 8 == 0) v = act_line(v, ($urandom % 2) ? 7 : 119);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd51377));
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) en_m[c][b] = 32'h0;
    mode_m = 1'b0;

    irq_in = ~INV_MASK;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    irq_in = INV_MASK;
    #1;
    check("R2 reset fwd", NL'(irq_fwd), '0);
    check("R2 reset wake", NL'(wake_out), '0);
    check("R2 reset rdata", NL'(bus_rdata), '0);

    // R2: every register reads zero after reset
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++)
        step(0, 1, AW'(c*1024 + b*4), 0, INV_MASK, "R2 enable reset");
    step(0, 1, 12'h800, 0, INV_MASK, "R2 mode reset");

    // R1: line 68 on CPU1 = register 2, bit 4 at 0x408
    step(1, 0, 12'h408, 32'h0000_0010, INV_MASK, "");
    step(0, 1, 12'h408, 0, INV_MASK, "R1 readback");
    step(0, 1, 12'h008, 0, INV_MASK, "R1 other cpu");
    step(0, 0, 0, 0, act_line(INV_MASK, 68), "");
    step(0, 0, 0, 0, act_line(INV_MASK, 69), "");

    // R7: mode keeps bit 5 only; then R5 independent wake
    step(1, 0, 12'h800, 32'hFFFF_FFFF, INV_MASK, "");
    step(0, 1, 12'h800, 0, act_line(INV_MASK, 68), "R7 mode bits");
    step(0, 0, 0, 0, act_line(INV_MASK, 68), "");

    // R7: unmapped and unaligned writes are ignored
    step(1, 0, 12'h014, 32'hFFFF_FFFF, INV_MASK, "");
    step(1, 0, 12'h7F0, 32'hFFFF_FFFF, INV_MASK, "");
    step(1, 0, 12'h804, 32'hFFFF_FFFF, INV_MASK, "");
    step(1, 0, 12'hC00, 32'hFFFF_FFFF, INV_MASK, "");
    step(1, 0, 12'h001, 32'hFFFF_FFFF, INV_MASK, "");
    step(1, 0, 12'h802, 32'h0, INV_MASK, "");
    step(0, 1, 12'h014, 0, ~INV_MASK, "R7 unmapped read");
    step(0, 1, 12'hC00, 0, ~INV_MASK, "R7 unmapped read");
    step(0, 1, 12'h001, 0, ~INV_MASK, "R7 unaligned read");
    step(0, 1, 12'h000, 0, INV_MASK, "R7 unaligned write ignored");
    step(0, 1, 12'h800, 0, INV_MASK, "R7 mode after bad write");

    // R4: line 7 active low, enabled on CPU0
    step(1, 0, 12'h000, 32'h0000_0080, INV_MASK, "");
    step(0, 0, 0, 0, INV_MASK, "");
    step(0, 0, 0, 0, act_line(INV_MASK, 7), "");
    step(0, 0, 0, 0, act_line(INV_MASK, 119), "");
    step(0, 0, 0, 0, '0, "");

    // R8: all ones then all zeros in CPU0 register 3
    step(1, 0, 12'h00C, 32'hFFFF_FFFF, INV_MASK, "");
    step(0, 1, 12'h00C, 0, act_line(INV_MASK, 100), "R8 all ones");
    step(0, 0, 0, 0, act_line(INV_MASK, 127), "");
    step(1, 0, 12'h00C, 32'h0, act_line(INV_MASK, 96), "");
    step(0, 1, 12'h00C, 0, act_line(INV_MASK, 96), "R8 all zeros");
    step(0, 0, 0, 0, act_line(INV_MASK, 110), "");

    // back to shared mode, R6
    step(1, 0, 12'h800, 32'h0, act_line(INV_MASK, 68), "");
    step(0, 0, 0, 0, act_line(INV_MASK, 68), "");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op, sel;
      logic [AW-1:0] a;
      logic [31:0] d;
      op  = int'($urandom % 100);
      sel = int'($urandom % 10);
      if (sel < 7)      a = AW'(($urandom % NC) * 1024 + ($urandom % NB) * 4);
      else if (sel < 8) a = 12'h800;
      else              a = AW'($urandom);
      case ($urandom % 4)
        0:       d = 32'hFFFF_FFFF;
        1:       d = 32'h0;
        default: d = $urandom;
      endcase
      if (op < 35)      step(1, 0, a, d, rand_irq(), "");
      else if (op < 70) step(0, 1, a, 0, rand_irq(), "R1/R7 random read");
      else              step(0, 0, a, 0, rand_irq(), "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule